// File: doc/BRIEF.md
# Bus Hold Request Arbiter

This block arbitrates ownership of the system bus between the local bus controller and an external master. The external master asks for the bus by pulling an active-low hold request low. The arbiter waits until the local bus reaches a cycle boundary. It then turns on the bus-float enable so that the local drivers release the pins. One state later it answers with an active-low hold acknowledge. The bus stays with the external master until the master releases the hold request. The acknowledge is then removed, and the float enable drops one state after that.

While the external master holds the bus, the arbiter raises an active-low bus request whenever the local controller has an external cycle waiting. This tells the master that it should give the bus back. The bus request never asserts before the acknowledge. Once asserted, it stays asserted until the hold request is released.

The whole handshake works only while a protocol-enable input is high. The same input locks the three shared pins into their hold, acknowledge and bus-request roles. Any port-configuration write that arrives during that time is discarded. A `cycle_allow` output tells the local controller when it may start a new external cycle.

Top module: `bus_hold_arbiter`

## Requirements
- R1: After reset, `hold_ack_n` and `bus_req_n` are 1, `bus_float` and `cycle_allow`'s internal hold state are clear, and the stored pin configuration equals parameter `CFG_RST` (default all zero).
- R2: In the idle state, with `proto_en`=1, `hold_req_n`=0 and `bus_busy`=0 at a clock edge, `bus_float` goes to 1 after that edge and `hold_ack_n` goes to 0 one edge later. `hold_ack_n` is never 0 while `bus_float` is 0.
- R3: No grant is started at an edge where `bus_busy`=1 or `proto_en`=0. The request waits and is granted at the first edge where the local bus is free.
- R4: The acknowledge holds for as long as `hold_req_n`=0, even if `proto_en` drops. At the first edge with `hold_req_n`=1, `hold_ack_n` returns to 1, and `bus_float` returns to 0 at the next edge.
- R5: `bus_req_n` is 0 only while `hold_ack_n` is 0. If `cycle_pending`=1 and `hold_req_n`=0 at the edge where the acknowledge asserts, `bus_req_n` falls at that same edge. Otherwise it falls at the first later edge with `cycle_pending`=1 while the bus is held.
- R6: Once `bus_req_n` is 0, it stays 0 even if `cycle_pending` drops. It returns to 1 at the same edge where `hold_ack_n` returns to 1.
- R7: `cycle_allow` is 1 only in the idle state with no grant requested (not (`proto_en`=1 and `hold_req_n`=0)). After a release it first returns to 1 in the state after `hold_ack_n` deasserts.
- R8: `pin_lock` equals `proto_en`. While it is 1, `pin_role` reads all ones (bit 0 hold input, bit 1 acknowledge, bit 2 bus request). While it is 0, `pin_role` shows the stored configuration.
- R9: A write (`cfg_wr`=1) at an edge with `proto_en`=0 stores `cfg_wdata`. A write at an edge with `proto_en`=1 is discarded, so the old value appears on `pin_role` once `proto_en` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_req_n | input | 1 | External master hold request, active low |
| proto_en | input | 1 | Enables the hold protocol and the pin lock |
| bus_busy | input | 1 | Local bus cycle in progress |
| cycle_pending | input | 1 | Local controller has an external cycle waiting |
| cfg_wr | input | 1 | Port-configuration write attempt |
| cfg_wdata | input | NPIN | Requested special-role bits for the shared pins |
| hold_ack_n | output | 1 | Hold acknowledge, active low |
| bus_req_n | output | 1 | Bus request toward the external master, active low |
| bus_float | output | 1 | Puts the local bus drivers in high impedance |
| cycle_allow | output | 1 | Local controller may start an external cycle |
| pin_lock | output | 1 | Pin reconfiguration locked |
| pin_role | output | NPIN | Effective special-role selection of the shared pins |

## Verification
The bench targets the following corner cases.

- **Hold request during a busy cycle.** A design that grants too early would float the bus in the middle of a local transfer.
- **Pending cycle at the grant edge versus later.** A bus request that leads the acknowledge by a state, or lags it when the cycle was already waiting, breaks the ordering rule.
- **Pending cycle that vanishes while the bus is held.** A design whose request merely follows `cycle_pending` lets `bus_req_n` bounce back high.
- **Release sequence.** The bench watches the acknowledge, the float enable and `cycle_allow` state by state, so a float that drops together with the acknowledge, or a local cycle allowed in the release state, shows up at once.
- **Configuration write while locked.** The bench makes this write, then clears the enable. A design that leaked the write shows the new value on `pin_role`.

// File: rtl/bha_pkg.sv
package bha_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FLOAT   = 2'd1,
    ST_HELD    = 2'd2,
    ST_RELEASE = 2'd3
  } hold_st_e;

  // A hold may be granted when the protocol is on, the request is low
  // and the local bus sits at a cycle boundary.
  function automatic logic grant_ok(input logic en, input logic req_n,
                                    input logic busy);
    return en & ~req_n & ~busy;
  endfunction

  // A hold is wanted (independent of the local bus state).
  function automatic logic hold_wanted(input logic en, input logic req_n);
    return en & ~req_n;
  endfunction

endpackage

// File: rtl/bha_seq.sv
module bha_seq
  import bha_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hold_req_n,
  input  logic     proto_en,
  input  logic     bus_busy,
  output hold_st_e state,
  output logic     grant_evt,
  output logic     release_evt,
  output logic     float_on,
  output logic     ack_on
);

  hold_st_e state_d;

  assign grant_evt   = (state == ST_IDLE) && grant_ok(proto_en, hold_req_n, bus_busy);
  assign release_evt = (state == ST_HELD) && hold_req_n;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:    if (grant_evt) state_d = ST_FLOAT;
      ST_FLOAT:   state_d = ST_HELD;
      ST_HELD:    if (release_evt) state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  assign float_on = (state != ST_IDLE);
  assign ack_on   = (state == ST_HELD);

endmodule

// File: rtl/bha_breq.sv
module bha_breq
  import bha_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  hold_st_e state,
  input  logic     hold_req_n,
  input  logic     cycle_pending,
  output logic     breq_set_evt,
  output logic     breq_clr_evt,
  output logic     breq_on
);

  // Set is only possible in the state before acknowledge or during it,
  // so the request can rise together with the acknowledge but not before.
  assign breq_set_evt = ((state == ST_FLOAT) || (state == ST_HELD)) &&
                        !hold_req_n && cycle_pending;
  assign breq_clr_evt = (state == ST_HELD) && hold_req_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            breq_on <= 1'b0;
    else if (breq_clr_evt) breq_on <= 1'b0;
    else if (breq_set_evt) breq_on <= 1'b1;
  end

endmodule

// File: rtl/bha_pincfg.sv
module bha_pincfg #(
  parameter int                NPIN    = 3,
  parameter logic [NPIN-1:0]   CFG_RST = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lock,
  input  logic            cfg_wr,
  input  logic [NPIN-1:0] cfg_wdata,
  output logic            cfg_take_evt,
  output logic [NPIN-1:0] pin_role
);

  localparam logic [NPIN-1:0] ROLE_FORCED = {NPIN{1'b1}};

  logic [NPIN-1:0] cfg_q;

  assign cfg_take_evt = cfg_wr && !lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cfg_q <= CFG_RST;
    else if (cfg_take_evt) cfg_q <= cfg_wdata;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_role
    assign pin_role[i] = lock ? ROLE_FORCED[i] : cfg_q[i];
  end

endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
  import bha_pkg::*;
#(
  parameter int              NPIN    = 3,
  parameter logic [NPIN-1:0] CFG_RST = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_req_n,
  input  logic            proto_en,
  input  logic            bus_busy,
  input  logic            cycle_pending,
  input  logic            cfg_wr,
  input  logic [NPIN-1:0] cfg_wdata,
  output logic            hold_ack_n,
  output logic            bus_req_n,
  output logic            bus_float,
  output logic            cycle_allow,
  output logic            pin_lock,
  output logic [NPIN-1:0] pin_role
);

  hold_st_e state;
  logic     grant_evt;
  logic     release_evt;
  logic     float_on;
  logic     ack_on;
  logic     breq_set_evt;
  logic     breq_clr_evt;
  logic     breq_on;
  logic     cfg_take_evt;

  bha_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_req_n  (hold_req_n),
    .proto_en    (proto_en),
    .bus_busy    (bus_busy),
    .state       (state),
    .grant_evt   (grant_evt),
    .release_evt (release_evt),
    .float_on    (float_on),
    .ack_on      (ack_on)
  );

  bha_breq u_breq (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state),
    .hold_req_n    (hold_req_n),
    .cycle_pending (cycle_pending),
    .breq_set_evt  (breq_set_evt),
    .breq_clr_evt  (breq_clr_evt),
    .breq_on       (breq_on)
  );

  bha_pincfg #(.NPIN(NPIN), .CFG_RST(CFG_RST)) u_pincfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .lock         (proto_en),
    .cfg_wr       (cfg_wr),
    .cfg_wdata    (cfg_wdata),
    .cfg_take_evt (cfg_take_evt),
    .pin_role     (pin_role)
  );

  assign hold_ack_n  = ~ack_on;
  assign bus_req_n   = ~breq_on;
  assign bus_float   = float_on;
  assign pin_lock    = proto_en;
  assign cycle_allow = (state == ST_IDLE) && !hold_wanted(proto_en, hold_req_n);

endmodule

// File: rtl/bha_chk.sv
module bha_chk #(
  parameter int NPIN = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hold_req_n,
  input logic            proto_en,
  input logic            bus_busy,
  input logic            hold_ack_n,
  input logic            bus_req_n,
  input logic            bus_float,
  input logic            cycle_allow,
  input logic            pin_lock,
  input logic [NPIN-1:0] pin_role,
  input logic            grant_evt,
  input logic            release_evt
);

  // R2
  ack_needs_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ack_n |-> bus_float);

  // R2
  float_leads_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack_n) |-> $past(bus_float));

  // R3
  grant_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_float) |-> $past(proto_en && !hold_req_n && !bus_busy));

  // R4
  release_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_ack_n && hold_req_n) |=> hold_ack_n);

  // R4
  float_trails_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_float) |-> ($past(hold_ack_n) && !$past(hold_ack_n, 2)));

  // R5
  breq_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req_n |-> !hold_ack_n);

  // R6
  breq_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req_n && !hold_req_n) |=> !bus_req_n);

  // R7
  allow_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_allow |-> (!bus_float && hold_ack_n && !grant_evt && !release_evt));

  // R8
  lock_roles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_lock |-> (pin_role == {NPIN{1'b1}}));

endmodule

bind bus_hold_arbiter bha_chk #(.NPIN(NPIN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hold_req_n  (hold_req_n),
  .proto_en    (proto_en),
  .bus_busy    (bus_busy),
  .hold_ack_n  (hold_ack_n),
  .bus_req_n   (bus_req_n),
  .bus_float   (bus_float),
  .cycle_allow (cycle_allow),
  .pin_lock    (pin_lock),
  .pin_role    (pin_role),
  .grant_evt   (grant_evt),
  .release_evt (release_evt)
);

// File: tb/test_bus_hold_arbiter.sv
module test_bus_hold_arbiter;

  localparam int NPIN = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            hold_req_n = 1'b1;
  logic            proto_en = 1'b0;
  logic            bus_busy = 1'b0;
  logic            cycle_pending = 1'b0;
  logic            cfg_wr = 1'b0;
  logic [NPIN-1:0] cfg_wdata = '0;
  logic            hold_ack_n;
  logic            bus_req_n;
  logic            bus_float;
  logic            cycle_allow;
  logic            pin_lock;
  logic [NPIN-1:0] pin_role;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // reference state: 0 idle, 1 floating, 2 held, 3 releasing
  int              m_st   = 0;
  bit              m_breq = 1'b0;
  logic [NPIN-1:0] m_cfg  = '0;

  always #5 clk = ~clk;

  bus_hold_arbiter #(.NPIN(NPIN)) i_bus_hold_arbiter (
    .clk, .rst_n, .hold_req_n, .proto_en, .bus_busy, .cycle_pending,
    .cfg_wr, .cfg_wdata, .hold_ack_n, .bus_req_n, .bus_float,
    .cycle_allow, .pin_lock, .pin_role
  );

  function automatic bit exp_allow(int st, bit en, bit h_n);
    if (st != 0) return 1'b0;
    return !(en == 1'b1 && h_n == 1'b0);
  endfunction

  function automatic logic [NPIN-1:0] exp_role(bit en, logic [NPIN-1:0] c);
    return en ? {NPIN{1'b1}} : c;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every output with the reference for the current state and inputs.
  task automatic check_all(string tag);
    check({tag, " ack"},   {7'd0, hold_ack_n},  {7'd0, !(m_st == 2)});
    check({tag, " float"}, {7'd0, bus_float},   {7'd0, m_st != 0});
    check({tag, " breq"},  {7'd0, bus_req_n},   {7'd0, !m_breq});
    check({tag, " allow"}, {7'd0, cycle_allow}, {7'd0, exp_allow(m_st, proto_en, hold_req_n)});
    check({tag, " lock"},  {7'd0, pin_lock},    {7'd0, proto_en});
    check({tag, " role"},  {5'd0, pin_role},    {5'd0, exp_role(proto_en, m_cfg)});
  endtask

  // Advance the reference across the coming clock edge.
  task automatic model_step();
    case (m_st)
      0: if (proto_en && !hold_req_n && !bus_busy) m_st = 1;
      1: begin m_st = 2; m_breq = cycle_pending && !hold_req_n; end
      2: if (hold_req_n) begin m_st = 3; m_breq = 1'b0; end
         else if (cycle_pending) m_breq = 1'b1;
      default: m_st = 0;
    endcase
    if (cfg_wr && !proto_en) m_cfg = cfg_wdata;
  endtask

  task automatic cyc(string tag, bit h_n, bit en, bit busy, bit pend,
                     bit wr, logic [NPIN-1:0] wd);
    @(negedge clk);
    hold_req_n = h_n; proto_en = en; bus_busy = busy;
    cycle_pending = pend; cfg_wr = wr; cfg_wdata = wd;
    #1;
    check_all(tag);
    model_step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 ack",   {7'd0, hold_ack_n}, 8'd1);
    check("R1 breq",  {7'd0, bus_req_n},  8'd1);
    check("R1 float", {7'd0, bus_float},  8'd0);
    check("R1 role",  {5'd0, pin_role},   8'd0);
    rst_n = 1'b1;

    // R3 hold while busy: no grant until busy clears; R2 grant sequence
    cyc("R3", 0, 1, 1, 0, 0, '0);
    cyc("R3", 0, 1, 1, 0, 0, '0);
    cyc("R2", 0, 1, 0, 0, 0, '0);
    cyc("R2", 0, 1, 0, 0, 0, '0);
    cyc("R5", 0, 1, 0, 1, 0, '0);   // pending arrives while held
    cyc("R6", 0, 1, 0, 0, 0, '0);   // pending drops, request stays
    cyc("R6", 0, 0, 0, 0, 0, '0);   // enable drops, hold continues (R4)
    cyc("R4", 1, 1, 0, 0, 0, '0);   // release
    cyc("R7", 1, 1, 0, 1, 0, '0);
    cyc("R7", 1, 1, 0, 1, 0, '0);
    // R5 pending already at the grant: request rises with acknowledge
    cyc("R5", 0, 1, 0, 1, 0, '0);
    cyc("R5", 0, 1, 0, 1, 0, '0);
    cyc("R5", 0, 1, 0, 1, 0, '0);
    cyc("R4", 1, 1, 0, 1, 0, '0);
    cyc("R4", 1, 1, 0, 1, 0, '0);
    // R3 disabled: request ignored
    cyc("R3", 0, 0, 0, 0, 0, '0);
    cyc("R3", 0, 0, 0, 0, 0, '0);
    // R9 write while locked is discarded, write while unlocked lands
    cyc("R9", 1, 0, 0, 0, 1, 3'b010);
    cyc("R9", 1, 1, 0, 0, 1, 3'b101);
    cyc("R8", 1, 1, 0, 0, 0, '0);
    cyc("R9", 1, 0, 0, 0, 0, '0);
    cyc("R9", 1, 0, 0, 0, 0, '0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit h_n, en, busy, pend, wr;
      h_n  = ($urandom % 8) < ((hold_req_n) ? 6 : 1) ? 1'b1 : 1'b0;
      en   = ($urandom % 16) != 0;
      busy = ($urandom % 3) == 0;
      pend = ($urandom % 4) == 0;
      wr   = ($urandom % 8) == 0;
      cyc("R2-rand", h_n, en, busy, pend, wr, NPIN'($urandom));
    end
    cyc("R7", 1, 0, 0, 0, 0, '0);
    cyc("R7", 1, 0, 0, 0, 0, '0);
    cyc("R7", 1, 0, 0, 0, 0, '0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule